// File: doc/BRIEF.md
# Rate-Modulated One-Bit Audio Delay

This block delays a delta-modulated audio bit stream by passing it through a circular one-bit memory. A sample strobe paces the memory. On each strobe the block reads the bit stored at the current location, writes the new input bit into that same location, and moves on to the next location. It wraps to location zero after the last location of the programmed length. The delay in seconds is therefore the number of locations in use divided by the strobe rate. A short ring gives the few-millisecond delays used for flanging and chorus, and a long ring gives echo-length delays.

The strobe comes from the carry out of a 24-bit phase accumulator, so any rate from near zero up to one strobe per clock can be chosen. A triangle oscillator adds a signed offset, scaled by a depth setting, to the accumulator increment. This sweeps the sample rate, and with it the delay time, without moving any pointer. The strobe is also brought out so that a downstream integrator can follow the modulated bit clock. Memory locations that have not been written since reset read back as an alternating 1/0 pattern, which is the one-bit code for silence.

Top module: `lfo_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `bit_out` = 0, `sample_tick` = 0, the ring position at 0, and the oscillator and accumulator cleared.
- R2: Each cycle the 24-bit accumulator adds the effective increment. `sample_tick` is the carry out of that addition, registered, so it is high in the cycle after the edge where the sum overflowed. With depth 0 the effective increment is `base_inc`.
- R3: The effective increment is clamped to the range 1 to 2^24-1. A sum below 1 gives 1, so `base_inc` = 0 gives no strobe for over 16 million cycles. A sum above 2^24-1 gives 2^24-1.
- R4: The oscillator is a signed value limited to ±(2^(LFO_W-1)-1). It starts at 0 and rises first. Once every LFO_DIV cycles it moves by `lfo_rate` in its current direction. If that move would reach or pass a limit, it stops at the limit and reverses direction.
- R5: The effective increment before clamping is `base_inc` plus (oscillator value × `lfo_depth`), with `lfo_depth` taken as unsigned. It is computed from the oscillator value held before the edge.
- R6: With an active length L = active setting + 1 (`len_cfg` gives length minus one), the bit presented at `bit_in` on a strobe edge appears at `bit_out` after the L-th following strobe edge, once that location has been written since reset.
- R7: On an edge without a strobe, `bit_out` and the ring position do not change.
- R8: A new `len_cfg` value is taken only on the strobe edge where the position equals the active length minus one. That edge also returns the position to 0. Reset loads `len_cfg` directly.
- R9: A strobe that reads a location not written since reset inverts `bit_out` instead of reading memory. The locations written since reset are those at or below the highest position written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Incoming one-bit audio stream, sampled on strobe edges |
| len_cfg | input | ADDR_W | Ring length minus one |
| base_inc | input | 24 | Unmodulated phase increment per clock |
| lfo_depth | input | DEPTH_W | Unsigned scale applied to the oscillator value |
| lfo_rate | input | RATE_W | Oscillator step size |
| bit_out | output | 1 | Delayed one-bit stream |
| sample_tick | output | 1 | Registered sample strobe (accumulator carry) |

## Verification
`sample_tick` goes high one cycle after the edge at which the accumulator overflowed. `bit_out` changes only on an edge where `sample_tick` is already high, so a delayed bit is due exactly L strobe edges after it was written. The bench drives inputs on falling edges. After every rising edge it advances an arithmetic model of the oscillator, accumulator and ring by that one edge, then compares the strobe and the output bit at the following falling edge. A failure therefore points to the exact cycle in which the mismatch appeared. Length changes, clamping at both ends and oscillator reversals are reached by sweeping a 16-location ring with a fast oscillator prescale.

// File: rtl/dly_pkg.sv
package dly_pkg;

    // Phase accumulator width; the strobe is its carry out.
    localparam int ACC_W = 24;

    typedef logic [ACC_W-1:0] phase_t;

    // Sweep direction of the triangle oscillator.
    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Result of one accumulator step: carry plus wrapped phase.
    typedef struct packed {
        logic   carry;
        phase_t sum;
    } acc_sum_t;

    // State of the one-bit ring that tells which locations hold written data.
    typedef struct packed {
        logic any;
        logic out;
    } ring_flags_t;

    function automatic acc_sum_t acc_add(phase_t a, phase_t b);
        acc_sum_t r;
        r = {1'b0, a} + {1'b0, b};
        return r;
    endfunction

endpackage

// File: rtl/tri_lfo.sv
module tri_lfo
    import dly_pkg::*;
#(
    parameter int LFO_W   = 16,
    parameter int RATE_W  = 8,
    parameter int LFO_DIV = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [RATE_W-1:0]       rate,
    output logic signed [LFO_W-1:0] lfo_val
);

    localparam int LIM_I = (1 << (LFO_W - 1)) - 1;
    localparam logic signed [LFO_W:0] LIM_P = (LFO_W + 1)'(LIM_I);
    localparam logic signed [LFO_W:0] LIM_N = -LIM_P;

    logic                  step_en;
    sweep_dir_e            dir_q;
    logic signed [LFO_W:0] cur_x;
    logic signed [LFO_W:0] stp_x;
    logic signed [LFO_W:0] up_x;
    logic signed [LFO_W:0] dn_x;

    // Prescaler: the oscillator moves once every LFO_DIV clocks.
    generate
        if (LFO_DIV > 1) begin : g_div
            localparam int CNT_W = $clog2(LFO_DIV);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LFO_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign step_en = (cnt_q == CNT_LAST);
        end else begin : g_nodiv
            assign step_en = 1'b1;
        end
    endgenerate

    always_comb begin
        cur_x = lfo_val;
        stp_x = signed'({{(LFO_W + 1 - RATE_W){1'b0}}, rate});
        up_x  = cur_x + stp_x;
        dn_x  = cur_x - stp_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfo_val <= '0;
            dir_q   <= SWEEP_UP;
        end else if (step_en) begin
            if (dir_q == SWEEP_UP) begin
                if (up_x >= LIM_P) begin
                    lfo_val <= LIM_P[LFO_W-1:0];
                    dir_q   <= SWEEP_DOWN;
                end else begin
                    lfo_val <= up_x[LFO_W-1:0];
                end
            end else begin
                if (dn_x <= LIM_N) begin
                    lfo_val <= LIM_N[LFO_W-1:0];
                    dir_q   <= SWEEP_UP;
                end else begin
                    lfo_val <= dn_x[LFO_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/phase_acc.sv
module phase_acc
    import dly_pkg::*;
#(
    parameter int LFO_W   = 16,
    parameter int DEPTH_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_t                  base,
    input  logic signed [LFO_W-1:0] lfo_val,
    input  logic [DEPTH_W-1:0]      depth,
    output phase_t                  inc,
    output logic                    tick
);

    localparam int PROD_W = LFO_W + DEPTH_W + 1;
    localparam int RAW_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;
    localparam logic signed [RAW_W-1:0] ONE_X = RAW_W'(1);
    localparam logic signed [RAW_W-1:0] MAX_X =
        signed'({{(RAW_W - ACC_W){1'b0}}, {ACC_W{1'b1}}});

    logic signed [PROD_W-1:0] prod;
    logic signed [RAW_W-1:0]  prod_x;
    logic signed [RAW_W-1:0]  base_x;
    logic signed [RAW_W-1:0]  raw;
    phase_t                   acc_q;
    acc_sum_t                 nxt;

    always_comb begin
        prod   = lfo_val * signed'({1'b0, depth});
        prod_x = prod;
        base_x = signed'({{(RAW_W - ACC_W){1'b0}}, base});
        raw    = base_x + prod_x;
        if (raw < ONE_X) begin
            inc = phase_t'(1);
        end else if (raw > MAX_X) begin
            inc = '1;
        end else begin
            inc = raw[ACC_W-1:0];
        end
        nxt = acc_add(acc_q, inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= nxt.sum;
            tick  <= nxt.carry;
        end
    end

endmodule

// File: rtl/bit_ring.sv
module bit_ring
    import dly_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] len_cfg,
    output logic              bit_out,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] len_act,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              mem [DEPTH];
    logic [ADDR_W-1:0] hi_q;
    ring_flags_t       flg_q;
    logic              wrap;

    assign rd_valid = flg_q.any && (addr <= hi_q);
    assign wrap     = (addr == len_act);
    assign bit_out  = flg_q.out;

    // Storage: written on each strobe, no reset.
    always_ff @(posedge clk) begin
        if (tick) begin
            mem[addr] <= bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            len_act <= len_cfg;
            hi_q    <= '0;
            flg_q   <= '{any: 1'b0, out: 1'b0};
        end else if (tick) begin
            flg_q.out <= rd_valid ? mem[addr] : ~flg_q.out;
            flg_q.any <= 1'b1;
            if (!flg_q.any || (addr > hi_q)) begin
                hi_q <= addr;
            end
            if (wrap) begin
                addr    <= '0;
                len_act <= len_cfg;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lfo_delay_line.sv
module lfo_delay_line
    import dly_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int LFO_W   = 16,
    parameter int RATE_W  = 8,
    parameter int DEPTH_W = 8,
    parameter int LFO_DIV = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_in,
    input  logic [ADDR_W-1:0]  len_cfg,
    input  logic [ACC_W-1:0]   base_inc,
    input  logic [DEPTH_W-1:0] lfo_depth,
    input  logic [RATE_W-1:0]  lfo_rate,
    output logic               bit_out,
    output logic               sample_tick
);

    logic signed [LFO_W-1:0] lfo_w;
    phase_t                  inc_w;
    logic [ADDR_W-1:0]       addr_w;
    logic [ADDR_W-1:0]       len_w;
    logic                    valid_w;

    tri_lfo #(
        .LFO_W  (LFO_W),
        .RATE_W (RATE_W),
        .LFO_DIV(LFO_DIV)
    ) u_lfo (
        .clk    (clk),
        .rst    (rst),
        .rate   (lfo_rate),
        .lfo_val(lfo_w)
    );

    phase_acc #(
        .LFO_W  (LFO_W),
        .DEPTH_W(DEPTH_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .base   (base_inc),
        .lfo_val(lfo_w),
        .depth  (lfo_depth),
        .inc    (inc_w),
        .tick   (sample_tick)
    );

    bit_ring #(
        .ADDR_W(ADDR_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .tick    (sample_tick),
        .bit_in  (bit_in),
        .len_cfg (len_cfg),
        .bit_out (bit_out),
        .addr    (addr_w),
        .len_act (len_w),
        .rd_valid(valid_w)
    );

endmodule

// File: rtl/dly_checker.sv
module dly_checker
    import dly_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LFO_W  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    bit_out,
    input phase_t                  inc,
    input logic signed [LFO_W-1:0] lfo_val,
    input logic [ADDR_W-1:0]       addr,
    input logic [ADDR_W-1:0]       len_act,
    input logic                    rd_valid
);

    localparam logic signed [LFO_W-1:0] LIM_S = LFO_W'((1 << (LFO_W - 1)) - 1);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!bit_out && !tick && addr == '0));  // R1

    AST_INC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        inc != '0);  // R3

    AST_LFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        (lfo_val <= LIM_S) && (lfo_val >= -LIM_S));  // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(bit_out) && $stable(addr)));  // R7

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && addr == len_act) |=> (addr == '0));  // R8

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tick && addr == len_act) |=> $stable(len_act));  // R8

    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        addr <= len_act);  // R6

    AST_SILENT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (tick && !rd_valid) |=> (bit_out != $past(bit_out)));  // R9

endmodule

bind lfo_delay_line dly_checker #(
    .ADDR_W(ADDR_W),
    .LFO_W (LFO_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (sample_tick),
    .bit_out (bit_out),
    .inc     (inc_w),
    .lfo_val (lfo_w),
    .addr    (addr_w),
    .len_act (len_w),
    .rd_valid(valid_w)
);

// File: tb/tb_lfo_delay_line.sv
module tb_lfo_delay_line;

    localparam int AW   = 4;
    localparam int LW   = 16;
    localparam int RW   = 8;
    localparam int DW   = 8;
    localparam int DIV  = 4;
    localparam int NLOC = 1 << AW;
    localparam longint LIM    = (64'sd1 << (LW - 1)) - 1;
    localparam longint ACCMAX = (64'sd1 << 24) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_in = 1'b0;
    logic [AW-1:0] len_cfg = '0;
    logic [23:0]   base_inc = '0;
    logic [DW-1:0] lfo_depth = '0;
    logic [RW-1:0] lfo_rate = '0;
    logic          bit_out;
    logic          sample_tick;

    int n_chk = 0;
    int n_fail = 0;
    string g_note = "";

    // Arithmetic model of the requirements
    longint m_acc, m_lfo;
    bit     m_tick, m_up, m_any, m_out, m_valid;
    int     m_div, m_addr, m_len, m_hi;
    bit     m_mem [NLOC];

    always #10 clk = ~clk;

    lfo_delay_line #(
        .ADDR_W (AW),
        .LFO_W  (LW),
        .RATE_W (RW),
        .DEPTH_W(DW),
        .LFO_DIV(DIV)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .len_cfg    (len_cfg),
        .base_inc   (base_inc),
        .lfo_depth  (lfo_depth),
        .lfo_rate   (lfo_rate),
        .bit_out    (bit_out),
        .sample_tick(sample_tick)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, g_note, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge, using the inputs held across it.
    task automatic model_edge();
        longint raw, inc, sum, nx;
        if (rst) begin
            m_acc = 0; m_tick = 0; m_lfo = 0; m_up = 1; m_div = 0;
            m_addr = 0; m_len = int'(len_cfg); m_hi = 0; m_any = 0; m_out = 0;
            m_valid = 0;
            return;
        end
        // ring (R6, R8, R9) acts on the strobe registered before this edge
        if (m_tick) begin
            m_valid = m_any && (m_addr <= m_hi);
            m_out = m_valid ? m_mem[m_addr] : !m_out;
            m_mem[m_addr] = bit_in;
            if (!m_any || m_addr > m_hi) m_hi = m_addr;
            m_any = 1;
            if (m_addr == m_len) begin
                m_addr = 0; m_len = int'(len_cfg);
            end else begin
                m_addr++;
            end
        end
        // accumulator (R2, R3, R5) uses the oscillator value before this edge
        raw = longint'(base_inc) + m_lfo * longint'(lfo_depth);
        inc = (raw < 1) ? 1 : ((raw > ACCMAX) ? ACCMAX : raw);
        sum = m_acc + inc;
        m_tick = (sum > ACCMAX);
        m_acc = sum & ACCMAX;
        // oscillator (R4)
        if (m_div == DIV - 1) begin
            m_div = 0;
            if (m_up) begin
                nx = m_lfo + longint'(lfo_rate);
                if (nx >= LIM) begin m_lfo = LIM; m_up = 0; end else m_lfo = nx;
            end else begin
                nx = m_lfo - longint'(lfo_rate);
                if (nx <= -LIM) begin m_lfo = -LIM; m_up = 1; end else m_lfo = nx;
            end
        end else begin
            m_div++;
        end
    endtask

    task automatic step(string tick_req);
        bit was_tick;
        @(negedge clk);
        was_tick = m_tick && !rst;
        model_edge();
        check(tick_req, longint'(sample_tick), longint'(m_tick));
        if (rst) check("R1", longint'(bit_out), 0);
        else if (!was_tick) check("R7", longint'(bit_out), longint'(m_out));
        else if (m_valid) check("R6", longint'(bit_out), longint'(m_out));
        else check("R9", longint'(bit_out), longint'(m_out));
        bit_in = 1'($urandom % 2);
    endtask

    task automatic run(string tick_req, int n);
        for (int i = 0; i < n; i++) step(tick_req);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        base_inc = 24'h800000;
        len_cfg = 4'd3;
        run("R1", 3);
        rst = 1'b0;
        check("R1", longint'(sample_tick), 0);
        check("R1", longint'(bit_out), 0);

        // R2, R6, R9: strobe every other clock, every ring length
        g_note = "len sweep";
        for (int l = 0; l < NLOC; l++) begin
            len_cfg = AW'(l);
            run("R2", 6 * (l + 1) + 8);
        end

        // R8: length grows and shrinks mid-pass; takes effect only at wrap
        g_note = "R8 length change";
        len_cfg = 4'd2;
        run("R2", 40);
        len_cfg = 4'd11;
        run("R2", 9);
        len_cfg = 4'd15;
        run("R2", 70);
        len_cfg = 4'd0;
        run("R2", 50);

        // R2: rate that is not a power of two
        g_note = "odd rate";
        base_inc = 24'd5000000;
        len_cfg = 4'd6;
        run("R2", 400);

        // R4, R5: swept rate without clamping, several reversals
        g_note = "R4 sweep";
        rst = 1'b1;
        base_inc = 24'h200000;
        lfo_depth = 8'd40;
        lfo_rate = 8'd150;
        run("R1", 2);
        rst = 1'b0;
        run("R5", 6000);

        // R3: negative sum clamps to one
        g_note = "low clamp";
        base_inc = 24'h100000;
        lfo_depth = 8'd255;
        run("R3", 4000);

        // R3: sum above range clamps to all ones
        g_note = "high clamp";
        base_inc = 24'hFFFFFF;
        run("R3", 2000);

        // R3: zero base rate with no sweep gives increment one, no strobe
        g_note = "zero rate";
        rst = 1'b1;
        base_inc = '0;
        lfo_depth = '0;
        run("R1", 2);
        rst = 1'b0;
        run("R3", 600);
        check("R3", longint'(sample_tick), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule